// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches a byte-wide receive stream, one Ethernet frame at a time, and decides at the last byte whether the frame is to be kept or thrown away. While the frame passes, it keeps a running byte position and records the destination address (bytes 0 to 5) and the type field (bytes 12 and 13). When the end-of-frame byte arrives, it combines four inputs into a single verdict: the address class (exact station match, broadcast, multicast or other unicast), the frame length, the CRC-bad flag and the pause-frame test. A configuration word sets the behaviour. It holds an enable bit, three address-acceptance bits, a bit that keeps bad frames, a bit that discards pause frames, a bit that strips the frame check sequence, and a bit that allows long frames.

The bytes are always forwarded on an output stream, whatever the verdict. The downstream buffer commits or discards the frame when the verdict pulse arrives, which comes in the same cycle as the last forwarded byte. With stripping off, the output stream is the input stream delayed by one cycle. With stripping on, the output runs four bytes behind the input, so the four CRC bytes are never delivered.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, and until the first input byte, `out_valid`, `out_sof`, `out_eof`, `verdict_valid`, `verdict_accept` and `verdict_err` are all 0.
- R2: `verdict_valid` pulses for exactly one cycle, in the cycle after the clock edge that takes in a byte with `in_valid` and `in_eof` both set, and at no other time. With `cfg[6]` clear, every input byte appears on `out_data` one cycle later, with its `sof` and `eof` marks.
- R3: With `cfg[0]` (receive enable) clear, every frame is given `verdict_accept` = 0.
- R4: A destination equal to `station_mac` is accepted. The first byte on the wire is `station_mac[47:40]`. Any other unicast destination is accepted only when `cfg[1]` is set.
- R5: A destination with bit 0 of its first byte set is multicast, and is accepted only when `cfg[2]` is set. The all-ones destination is broadcast and is accepted only when `cfg[3]` is set. It does not fall back on the multicast bit.
- R6: The length counts every byte, including the CRC. A length below 64 is dropped. A length above 1536 is dropped, unless `cfg[7]` is set, which raises the upper limit to `LONG_MAX` (default 9018).
- R7: A frame with `in_crc_bad` set on its last byte is dropped when `cfg[4]` is clear. When `cfg[4]` is set, the frame is judged like any other, and an accepted frame also raises `verdict_err`.
- R8: With `cfg[5]` set, a frame with destination 01-80-C2-00-00-01 and type 0x8808 is dropped. A frame with type 0x8808 sent to any other address is not affected.
- R9: With `cfg[6]` set, byte n of the frame appears on `out_data` together with input byte n+4. The first forwarded byte carries `out_sof`, the byte forwarded with the end-of-frame input carries `out_eof`, and the last four bytes are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 8 | Receive configuration word; bits listed in R3 to R9 |
| station_mac | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of the frame |
| in_eof | input | 1 | Last byte of the frame |
| in_data | input | 8 | Input byte |
| in_crc_bad | input | 1 | CRC check failed; sampled with the last byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_sof | output | 1 | First forwarded byte |
| out_eof | output | 1 | Last forwarded byte |
| out_data | output | 8 | Forwarded byte |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict_accept | output | 1 | Frame is to be kept |
| verdict_err | output | 1 | Kept frame carries a CRC error |

## Verification
A wrong byte position shows in two places. The frame gets the wrong verdict, because the length or the captured address is off. With stripping on, the forwarded bytes and their sof and eof marks shift by one, one cycle after the byte that went astray. A stale captured destination or type field only shows at the end of the frame, as a wrong `verdict_accept` in the cycle after the last byte. This is why every address class, every length boundary, the CRC policy and the pause-frame test are each run in both their kept and dropped settings. The reference model compares every output in every cycle, so a stray verdict pulse or an extra forwarded byte is reported in the cycle it appears.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic long_ok;     // bit 7
    logic strip_fcs;   // bit 6
    logic drop_pause;  // bit 5
    logic keep_bad;    // bit 4
    logic bcast_ok;    // bit 3
    logic mcast_all;   // bit 2
    logic ucast_all;   // bit 1
    logic enable;      // bit 0
  } rx_cfg_t;

  localparam logic [47:0] BCAST_ADDR = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] PAUSE_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] PAUSE_TYPE = 16'h8808;

  // address class test: exact match, then broadcast, then multicast, else unicast
  function automatic logic addr_pass(rx_cfg_t c, logic [47:0] sta, logic [47:0] dst);
    logic ok;
    if (dst == sta)             ok = 1'b1;
    else if (dst == BCAST_ADDR) ok = c.bcast_ok;
    else if (dst[40])           ok = c.mcast_all;
    else                        ok = c.ucast_all;
    return ok;
  endfunction

  function automatic logic is_pause(logic [47:0] dst, logic [15:0] typ);
    return (dst == PAUSE_ADDR) && (typ == PAUSE_TYPE);
  endfunction

  // returns {accept, err}
  function automatic logic [1:0] judge(rx_cfg_t c, logic [47:0] sta, logic [47:0] dst,
                                       logic [15:0] typ, logic len_ok, logic bad);
    logic acc;
    acc = c.enable & len_ok & addr_pass(c, sta, dst)
        & ~(bad & ~c.keep_bad) & ~(c.drop_pause & is_pause(dst, typ));
    return {acc, acc & bad};
  endfunction

endpackage

// File: rtl/rxf_hdr_track.sv
module rxf_hdr_track #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [7:0]    in_data,
  output logic [CW-1:0] pos,
  output logic [47:0]   dst_q,
  output logic [15:0]   typ_q
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] cnt;

  // position of the byte currently presented
  assign pos = in_sof ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      dst_q <= '0;
      typ_q <= '0;
    end else if (in_valid) begin
      cnt <= (pos == SAT) ? SAT : pos + 1'b1;
      for (int k = 0; k < 6; k++)
        if (pos == CW'(k)) dst_q[(5-k)*8 +: 8] <= in_data;
      if (pos == CW'(12)) typ_q[15:8] <= in_data;
      if (pos == CW'(13)) typ_q[7:0]  <= in_data;
    end
  end
endmodule

// File: rtl/rxf_fcs_strip.sv
module rxf_fcs_strip #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strip,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic [CW-1:0] pos,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof,
  output logic [7:0]    out_data
);
  localparam int DEPTH = 4;

  logic [7:0] sr [DEPTH];
  logic       deep;  // event: current byte lies at least DEPTH bytes into the frame

  assign deep = (pos >= CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else if (in_valid) begin
      sr[0] <= in_data;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
    end else if (strip) begin
      out_valid <= in_valid & deep;
      out_sof   <= in_valid & (pos == CW'(DEPTH));
      out_eof   <= in_valid & in_eof & deep;
      out_data  <= sr[DEPTH-1];
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid & in_sof;
      out_eof   <= in_valid & in_eof;
      out_data  <= in_data;
    end
  end

  // R9: nothing leaves without a byte entering in the cycle before
  p_out_follows_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R9: with stripping, the first forwarded byte is launched by input byte 4
  p_strip_sof_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && $past(strip)) |-> ($past(pos) == CW'(DEPTH)));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int LW       = 15,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1536,
  parameter int LONG_MAX = 9018
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  rx_cfg_t       cfg,
  input  logic [47:0]   station,
  input  logic [47:0]   dst,
  input  logic [15:0]   typ,
  input  logic [LW-1:0] len,
  input  logic          bad,
  output logic          verdict_valid,
  output logic          verdict_accept,
  output logic          verdict_err
);
  localparam logic [LW-1:0] MIN_L  = LW'(MIN_LEN);
  localparam logic [LW-1:0] MAX_L  = LW'(MAX_LEN);
  localparam logic [LW-1:0] LONG_L = LW'(LONG_MAX);

  logic       len_ok;   // event: length inside the active window
  logic [1:0] res;

  assign len_ok = (len >= MIN_L) && (len <= (cfg.long_ok ? LONG_L : MAX_L));
  assign res    = judge(cfg, station, dst, typ, len_ok, bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
      verdict_err    <= 1'b0;
    end else begin
      verdict_valid  <= fire;
      verdict_accept <= fire & res[1];
      verdict_err    <= fire & res[0];
    end
  end

  // R2: a verdict only follows an end-of-frame byte
  p_verdict_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(fire));
  // R3: disabled receiver keeps nothing
  p_off_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !$past(cfg.enable)) |-> !verdict_accept);
  // R6: runt frames are never kept
  p_runt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && ($past(len) < MIN_L)) |-> !verdict_accept);
  // R7: error mark needs a flagged, kept frame
  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_err |-> ($past(bad) && verdict_accept));
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1536,
  parameter int LONG_MAX = 9018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg,
  input  logic [47:0] station_mac,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        in_crc_bad,
  output logic        out_valid,
  output logic        out_sof,
  output logic        out_eof,
  output logic [7:0]  out_data,
  output logic        verdict_valid,
  output logic        verdict_accept,
  output logic        verdict_err
);
  localparam int CW = $clog2(LONG_MAX + 2);
  localparam int LW = CW + 1;

  rx_cfg_t       cfg_s;
  logic [CW-1:0] pos;
  logic [47:0]   dst_q;
  logic [15:0]   typ_q;
  logic [LW-1:0] frame_len;
  logic          eof_fire;

  assign cfg_s     = rx_cfg_t'(cfg);
  assign frame_len = {1'b0, pos} + 1'b1;
  assign eof_fire  = in_valid & in_eof;

  rxf_hdr_track #(.CW(CW)) u_hdr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .pos(pos), .dst_q(dst_q), .typ_q(typ_q)
  );

  rxf_fcs_strip #(.CW(CW)) u_strip (
    .clk(clk), .rst_n(rst_n), .strip(cfg_s.strip_fcs), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .pos(pos),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
  );

  rxf_decide #(.LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LONG_MAX(LONG_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(eof_fire), .cfg(cfg_s), .station(station_mac),
    .dst(dst_q), .typ(typ_q), .len(frame_len), .bad(in_crc_bad),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept), .verdict_err(verdict_err)
  );

  // R2: one verdict per end-of-frame byte, and only after one
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eof) |-> verdict_valid);
endmodule

// File: tb/rx_accept_filter_tb_top.sv
module rx_accept_filter_tb_top;
  localparam int LMAX = 9018;
  localparam logic [47:0] STA = 48'h0012_3456_789A;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_bad = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_sof, out_eof, verdict_valid, verdict_accept, verdict_err;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  rx_accept_filter #(.LONG_MAX(LMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .station_mac(STA),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_crc_bad(in_crc_bad), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept), .verdict_err(verdict_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit e_v, e_sof, e_eof, e_vv, e_acc, e_err;
  logic [7:0] e_d;
  string e_stag = "R1", e_vtag = "R1";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_v, e_stag, "out_valid", out_valid, e_v);
    chk(out_sof == e_sof, e_stag, "out_sof", out_sof, e_sof);
    chk(out_eof == e_eof, e_stag, "out_eof", out_eof, e_eof);
    if (e_v) chk(out_data == e_d, e_stag, "out_data", out_data, e_d);
    chk(verdict_valid == e_vv, e_vtag, "verdict_valid", verdict_valid, e_vv);
    chk(verdict_accept == e_acc, e_vtag, "verdict_accept", verdict_accept, e_acc);
    chk(verdict_err == e_err, e_vtag, "verdict_err", verdict_err, e_err);
  endtask

  function automatic void ref_verdict(logic [7:0] c, logic [47:0] d, int t, int len,
                                      bit bad, output bit acc, output bit err);
    int hi;
    bit aok;
    hi = c[7] ? LMAX : 1536;
    if (d == STA) aok = 1;
    else if (d == {48{1'b1}}) aok = c[3];
    else if (d[40]) aok = c[2];
    else aok = c[1];
    acc = c[0] && aok && len >= 64 && len <= hi;
    if (bad && !c[4]) acc = 0;
    if (c[5] && t == 'h8808 && d == 48'h0180C2000001) acc = 0;
    err = acc && bad;
  endfunction

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      in_valid = 0; in_sof = 0; in_eof = 0; in_crc_bad = 0;
      e_v = 0; e_sof = 0; e_eof = 0; e_vv = 0; e_acc = 0; e_err = 0;
    end
  endtask

  task automatic send(logic [7:0] c, logic [47:0] d, int t, int len, bit bad, string tag);
    logic [7:0] q[$];
    bit acc, err, s;
    for (int k = 0; k < 6; k++) q.push_back(d[47-8*k -: 8]);
    for (int k = 0; k < 6; k++) q.push_back(8'h20 + 8'(k));
    q.push_back(8'(t >> 8));
    q.push_back(8'(t));
    while (q.size() < len) q.push_back(8'(q.size() * 13 + len));
    q = q[0:len-1];
    ref_verdict(c, d, t, len, bad, acc, err);
    s = c[6];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      compare();
      cfg = c;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = q[i]; in_crc_bad = bad && (i == len - 1);
      e_stag = s ? "R9" : "R2";
      e_vtag = tag;
      if (s) begin
        e_v = (i >= 4); e_sof = (i == 4); e_eof = (i == len - 1) && (i >= 4);
        e_d = (i >= 4) ? q[i-4] : 8'h00;
      end else begin
        e_v = 1; e_sof = (i == 0); e_eof = (i == len - 1); e_d = q[i];
      end
      e_vv = (i == len - 1); e_acc = e_vv && acc; e_err = e_vv && err;
    end
    idle(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();               // R1 while in reset
    @(negedge clk);
    rst_n = 1;
    e_stag = "R1"; e_vtag = "R1";
    idle(3);                 // R1 after reset release
    // R4 exact match, minimum length
    send(8'h01, STA, 'h0800, 64, 0, "R4");
    // R3 receiver off
    send(8'h00, STA, 'h0800, 64, 0, "R3");
    send(8'h0E, 48'hFFFF_FFFF_FFFF, 'h0800, 80, 0, "R3");
    // R4 other unicast
    send(8'h01, 48'h0012_3456_789B, 'h0800, 70, 0, "R4");
    send(8'h03, 48'h0012_3456_789B, 'h0800, 70, 0, "R4");
    // R5 multicast and broadcast
    send(8'h01, 48'h0100_5E00_0001, 'h0800, 72, 0, "R5");
    send(8'h05, 48'h0100_5E00_0001, 'h0800, 72, 0, "R5");
    send(8'h09, 48'hFFFF_FFFF_FFFF, 'h0806, 64, 0, "R5");
    send(8'h05, 48'hFFFF_FFFF_FFFF, 'h0806, 64, 0, "R5");
    // R6 length limits
    send(8'h01, STA, 'h0800, 63, 0, "R6");
    send(8'h01, STA, 'h0800, 1536, 0, "R6");
    send(8'h01, STA, 'h0800, 1537, 0, "R6");
    send(8'h81, STA, 'h0800, 1537, 0, "R6");
    send(8'h81, STA, 'h0800, LMAX, 0, "R6");
    send(8'h81, STA, 'h0800, LMAX + 1, 0, "R6");
    // R7 CRC policy
    send(8'h01, STA, 'h0800, 100, 1, "R7");
    send(8'h11, STA, 'h0800, 100, 1, "R7");
    send(8'h11, 48'h0012_3456_0000, 'h0800, 100, 1, "R7");
    // R8 pause frames
    send(8'h25, 48'h0180_C200_0001, 'h8808, 64, 0, "R8");
    send(8'h05, 48'h0180_C200_0001, 'h8808, 64, 0, "R8");
    send(8'h25, 48'h0180_C200_0002, 'h8808, 64, 0, "R8");
    send(8'h25, 48'h0180_C200_0001, 'h0800, 64, 0, "R8");
    // R9 CRC strip
    send(8'h41, STA, 'h0800, 64, 0, "R9");
    send(8'h41, STA, 'h0800, 200, 1, "R9");
    send(8'h43, 48'h0012_0000_0001, 'h0800, 65, 0, "R9");
    send(8'h01, STA, 'h0800, 66, 0, "R2");
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule